// File: doc/BRIEF.md
# Parameter Page Validator

This block checks the device parameter page that a standardized NAND flash returns after a read-parameter command. It also decodes the page's geometry. Another part of the controller issues that command. This block sees only the resulting byte stream, one byte per cycle while `byte_valid` is high. The device stores several identical 256-byte copies of the page back to back. After a `start` pulse, the block examines up to three of these copies in turn.

Each copy is judged on two checks:
- A signature vote over its first four bytes.
- A CRC-16 over its first 254 bytes, compared with the checksum stored in its last two bytes.

The first copy that passes both checks is accepted. Its geometry fields go to the outputs, together with a one-cycle `param_valid` pulse. If all three copies are rejected, a one-cycle `param_fail` pulse is raised and the outputs keep their earlier contents. Values decoded from a rejected copy never reach the outputs.

Top module: `ppage_validator`

## Requirements
- R1: While reset is held, and after it is released until the first verdict, every geometry output, `accepted_copy`, `param_valid` and `param_fail` is zero.
- R2: The checksum over bytes 0 to 253 of a copy is computed MSB-first with polynomial 0x8005. It is reseeded to 0x4F4E for every copy. For each byte, the byte is XORed into bits 15:8 and then eight shift steps follow. The result is compared with the stored value: byte 254 holds the low half and byte 255 the high half. A change to any covered byte, including byte 253, or to the stored value, rejects the copy.
- R3: Bytes 0 to 3 are compared one by one against the ASCII characters O, N, F, I. The signature passes when two or more of the four positions match, and fails when only one or none does.
- R4: A copy is accepted only when both the signature and the checksum pass.
- R5: A rejected copy leads to the next copy, up to three copies in total. A rejection of copy 0 or copy 1 raises neither pulse. A rejection of copy 2 raises `param_fail` for one cycle.
- R6: Multi-byte fields are little-endian at fixed byte offsets within the copy:
  - bytes per page: 4 bytes at offset 80
  - spare bytes per page: 2 bytes at offset 84
  - pages per block: 4 bytes at offset 92
  - blocks per LUN: 4 bytes at offset 96
  - LUN count: 1 byte at offset 100
- R7: Byte 101 holds the address cycle counts. Its bits 7:4 give the column address cycle count and bits 3:0 give the row address cycle count.
- R8: `param_valid` is high for exactly one cycle. It rises in the cycle after byte 255 of the accepted copy is taken. The geometry outputs and `accepted_copy` (0, 1 or 2) change only in that same cycle and otherwise hold their value.
- R9: Bytes offered while no validation is in progress are ignored and produce no pulse. A `start` pulse given partway through a copy restarts from copy 0, byte 0.
- R10: Cycles with `byte_valid` low do not advance the byte position, so gaps anywhere in the stream give the same verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin (or restart) validation at copy 0, byte 0 |
| byte_valid | input | 1 | `byte_data` carries the next page byte this cycle |
| byte_data | input | 8 | Page byte |
| param_valid | output | 1 | One-cycle pulse: a copy was accepted and the outputs were updated |
| param_fail | output | 1 | One-cycle pulse: all three copies were rejected |
| accepted_copy | output | 2 | Index of the accepted copy |
| bytes_per_page | output | 32 | Decoded bytes per page |
| spare_bytes_per_page | output | 16 | Decoded spare bytes per page |
| pages_per_block | output | 32 | Decoded pages per block |
| blocks_per_lun | output | 32 | Decoded blocks per LUN |
| lun_count | output | 8 | Decoded LUN count |
| col_addr_cycles | output | 4 | Column address cycle count |
| row_addr_cycles | output | 4 | Row address cycle count |

## Verification
Faults in the internal state show up at the ports within one copy (256 accepted bytes):
- A checksum register that was not reseeded, or that covered one byte too few or too many, turns a good copy into a rejection. That shows as a missing `param_valid`, or as a wrong `accepted_copy`, in the cycle after byte 255.
- A signature counter that leaks across copies makes a copy with only one matching signature byte pass when it should fail.
- A byte position that drifts during input gaps, or a field lane with the wrong offset, produces wrong geometry values at that same pulse.
- A copy counter that is off by one ends the attempt a copy early or late, which is visible as `param_fail` arriving at the wrong point.

// File: rtl/ppv_pkg.sv
// Package: shared constants and helpers for the parameter page validator.
// Assumes byte-serial input and pages of at most 256 bytes.
package ppv_pkg;

    localparam logic [15:0] PPV_CRC_SEED = 16'h4F4E;
    localparam logic [15:0] PPV_CRC_POLY = 16'h8005;
    localparam int          PPV_SIG_LEN  = 4;

    // Byte offsets of the decoded fields (device layout, behaviour-relevant)
    localparam int OFS_PAGE_BYTES  = 80;
    localparam int OFS_SPARE_BYTES = 84;
    localparam int OFS_PAGES_BLK   = 92;
    localparam int OFS_BLKS_LUN    = 96;
    localparam int OFS_LUNS        = 100;
    localparam int OFS_ADDR_CYC    = 101;

    // One CRC-16 byte step, MSB-first: XOR into the top byte, then eight shifts
    function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                               input logic [7:0]  din,
                                               input logic [15:0] poly);
        logic [15:0] c;
        c = cur ^ {din, 8'h00};
        for (int b = 0; b < 8; b++) begin
            if (c[15]) c = {c[14:0], 1'b0} ^ poly;
            else       c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

    // Expected signature character at position 0..3
    function automatic logic [7:0] sig_char(input logic [1:0] pos);
        case (pos)
            2'd0:    return 8'h4F;
            2'd1:    return 8'h4E;
            2'd2:    return 8'h46;
            default: return 8'h49;
        endcase
    endfunction

endpackage

// File: rtl/ppv_crc16.sv
// Module: streaming CRC-16 over the covered bytes of one page copy.
// Assumes: init and en are never needed in the same cycle with different
// intent; init wins and reloads the seed.
module ppv_crc16 #(
    parameter logic [15:0] SEED = ppv_pkg::PPV_CRC_SEED,
    parameter logic [15:0] POLY = ppv_pkg::PPV_CRC_POLY
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    logic [15:0] crc_q;

    // Purpose: reseed on init, fold one byte in when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= SEED;
        else if (init) crc_q <= SEED;
        else if (en)   crc_q <= ppv_pkg::crc16_step(crc_q, din, POLY);
    end

    assign crc = crc_q;

    // R2
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !en) |=> $stable(crc_q));

endmodule

// File: rtl/ppv_sig_vote.sv
// Module: counts how many of the four signature positions hold the expected
// character and reports whether the count reaches the vote threshold.
// Assumes idx is the byte position within the current copy.
module ppv_sig_vote #(
    parameter int IDX_W   = 8,
    parameter int SIG_MIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       din,
    output logic             pass
);
    localparam int          CNT_W   = $clog2(ppv_pkg::PPV_SIG_LEN + 1);
    localparam logic [IDX_W-1:0] SIG_END = IDX_W'(ppv_pkg::PPV_SIG_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    // Purpose: decide whether the present byte is a matching signature byte
    always_comb begin
        hit = en && (idx < SIG_END) && (din == ppv_pkg::sig_char(idx[1:0]));
    end

    // Purpose: accumulate matches for the current copy
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (hit)   cnt_q <= cnt_q + 1'b1;
    end

    assign pass = (cnt_q >= CNT_W'(SIG_MIN));

    // R3
    sig_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/ppv_le_field.sv
// Module: captures a little-endian field of NBYTES bytes starting at OFFSET
// within the current copy. Lane k takes the byte at position OFFSET+k.
// Assumes OFFSET+NBYTES fits in the index range.
module ppv_le_field #(
    parameter int IDX_W  = 8,
    parameter int OFFSET = 0,
    parameter int NBYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [IDX_W-1:0]      idx,
    input  logic [7:0]            din,
    output logic [8*NBYTES-1:0]   value
);
    logic [7:0] lane_q [NBYTES];

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        localparam logic [IDX_W-1:0] LANE_IDX = IDX_W'(OFFSET + k);
        // Purpose: latch this lane's byte when its position passes
        always_ff @(posedge clk) begin
            if (!rst_n)                     lane_q[k] <= '0;
            else if (en && idx == LANE_IDX) lane_q[k] <= din;
        end
    end

    // Purpose: assemble lanes, lowest address in the least significant byte
    always_comb begin
        for (int k = 0; k < NBYTES; k++) value[8*k +: 8] = lane_q[k];
    end

endmodule

// File: rtl/ppage_validator.sv
// Module: top of the parameter page validator. Walks up to MAX_COPIES
// copies, votes on the signature, checks the CRC, and publishes the geometry
// of the first copy that passes both. Assumes the byte stream begins at byte 0
// of copy 0 after start, and that copies follow one another with no filler.
module ppage_validator #(
    parameter int          PAGE_BYTES = 256,
    parameter int          MAX_COPIES = 3,
    parameter int          SIG_MIN    = 2,
    parameter logic [15:0] CRC_SEED   = ppv_pkg::PPV_CRC_SEED,
    parameter logic [15:0] CRC_POLY   = ppv_pkg::PPV_CRC_POLY
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    output logic        param_valid,
    output logic        param_fail,
    output logic [1:0]  accepted_copy,
    output logic [31:0] bytes_per_page,
    output logic [15:0] spare_bytes_per_page,
    output logic [31:0] pages_per_block,
    output logic [31:0] blocks_per_lun,
    output logic [7:0]  lun_count,
    output logic [3:0]  col_addr_cycles,
    output logic [3:0]  row_addr_cycles
);
    localparam int               IDX_W    = $clog2(PAGE_BYTES);
    localparam int               COPY_W   = 2;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAGE_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_CLO  = IDX_W'(PAGE_BYTES - 2);
    localparam logic [COPY_W-1:0] COPY_LAST = COPY_W'(MAX_COPIES - 1);

    logic              busy_q;
    logic [IDX_W-1:0]  idx_q;
    logic [COPY_W-1:0] copy_q;
    logic [7:0]        stored_lo_q;
    logic              ok_q, fail_q;
    logic              accept, last_byte, crc_en, crc_match, sig_pass, copy_ok;
    logic              next_copy, reseed;
    logic [15:0]       crc_val;

    logic [31:0] f_page_bytes, f_pages_blk, f_blks_lun;
    logic [15:0] f_spare;
    logic [7:0]  f_luns, f_acyc;

    // Purpose: qualify bytes and derive per-copy control strobes
    always_comb begin
        accept    = busy_q && byte_valid && !start;
        last_byte = accept && (idx_q == IDX_LAST);
        crc_en    = accept && (idx_q < IDX_CLO);
        crc_match = (crc_val == {byte_data, stored_lo_q});
        copy_ok   = crc_match && sig_pass;
        next_copy = last_byte && !copy_ok && (copy_q != COPY_LAST);
        reseed    = start || next_copy;
    end

    ppv_crc16 #(.SEED(CRC_SEED), .POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(reseed), .en(crc_en),
        .din(byte_data), .crc(crc_val)
    );

    ppv_sig_vote #(.IDX_W(IDX_W), .SIG_MIN(SIG_MIN)) u_sig (
        .clk(clk), .rst_n(rst_n), .clear(reseed), .en(accept),
        .idx(idx_q), .din(byte_data), .pass(sig_pass)
    );

    ppv_le_field #(.IDX_W(IDX_W), .OFFSET(ppv_pkg::OFS_PAGE_BYTES), .NBYTES(4)) u_f_pb (
        .clk(clk), .rst_n(rst_n), .en(accept), .idx(idx_q), .din(byte_data), .value(f_page_bytes));
    ppv_le_field #(.IDX_W(IDX_W), .OFFSET(ppv_pkg::OFS_SPARE_BYTES), .NBYTES(2)) u_f_sp (
        .clk(clk), .rst_n(rst_n), .en(accept), .idx(idx_q), .din(byte_data), .value(f_spare));
    ppv_le_field #(.IDX_W(IDX_W), .OFFSET(ppv_pkg::OFS_PAGES_BLK), .NBYTES(4)) u_f_ppb (
        .clk(clk), .rst_n(rst_n), .en(accept), .idx(idx_q), .din(byte_data), .value(f_pages_blk));
    ppv_le_field #(.IDX_W(IDX_W), .OFFSET(ppv_pkg::OFS_BLKS_LUN), .NBYTES(4)) u_f_bpl (
        .clk(clk), .rst_n(rst_n), .en(accept), .idx(idx_q), .din(byte_data), .value(f_blks_lun));
    ppv_le_field #(.IDX_W(IDX_W), .OFFSET(ppv_pkg::OFS_LUNS), .NBYTES(1)) u_f_lun (
        .clk(clk), .rst_n(rst_n), .en(accept), .idx(idx_q), .din(byte_data), .value(f_luns));
    ppv_le_field #(.IDX_W(IDX_W), .OFFSET(ppv_pkg::OFS_ADDR_CYC), .NBYTES(1)) u_f_ac (
        .clk(clk), .rst_n(rst_n), .en(accept), .idx(idx_q), .din(byte_data), .value(f_acyc));

    // Purpose: hold the low half of the stored checksum until the high half arrives
    always_ff @(posedge clk) begin
        if (!rst_n)                              stored_lo_q <= '0;
        else if (accept && idx_q == IDX_CLO)     stored_lo_q <= byte_data;
    end

    // Purpose: sequence byte position, copy retries and the verdict pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            copy_q <= '0;
            ok_q   <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            ok_q   <= 1'b0;
            fail_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                copy_q <= '0;
            end else if (accept) begin
                if (last_byte) begin
                    idx_q <= '0;
                    if (copy_ok) begin
                        busy_q <= 1'b0;
                        ok_q   <= 1'b1;
                    end else if (copy_q == COPY_LAST) begin
                        busy_q <= 1'b0;
                        fail_q <= 1'b1;
                    end else begin
                        copy_q <= copy_q + 1'b1;
                    end
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Purpose: publish the geometry of an accepted copy only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accepted_copy        <= '0;
            bytes_per_page       <= '0;
            spare_bytes_per_page <= '0;
            pages_per_block      <= '0;
            blocks_per_lun       <= '0;
            lun_count            <= '0;
            col_addr_cycles      <= '0;
            row_addr_cycles      <= '0;
        end else if (!start && last_byte && copy_ok) begin
            accepted_copy        <= copy_q;
            bytes_per_page       <= f_page_bytes;
            spare_bytes_per_page <= f_spare;
            pages_per_block      <= f_pages_blk;
            blocks_per_lun       <= f_blks_lun;
            lun_count            <= f_luns;
            col_addr_cycles      <= f_acyc[7:4];
            row_addr_cycles      <= f_acyc[3:0];
        end
    end

    assign param_valid = ok_q;
    assign param_fail  = fail_q;

    // R4
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(param_valid && param_fail));

    // R5
    fail_last_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        param_fail |-> ($past(copy_q) == COPY_LAST && $past(byte_valid)));

    // R5
    copy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_q <= COPY_LAST);

    // R8
    geom_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({bytes_per_page, spare_bytes_per_page, pages_per_block,
                  blocks_per_lun, lun_count, col_addr_cycles, row_addr_cycles,
                  accepted_copy}) |-> param_valid);

    // R8
    valid_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        param_valid |-> ($past(byte_valid) && !$past(start)));

    // R9
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |=> !(param_valid || param_fail));

endmodule

// File: tb/ppage_validator_tb.sv
module ppage_validator_tb;

    logic        clk = 1'b0;
    logic        rst_n, start, byte_valid;
    logic [7:0]  byte_data;
    logic        param_valid, param_fail;
    logic [1:0]  accepted_copy;
    logic [31:0] bytes_per_page, pages_per_block, blocks_per_lun;
    logic [15:0] spare_bytes_per_page;
    logic [7:0]  lun_count;
    logic [3:0]  col_addr_cycles, row_addr_cycles;

    always #5 clk = ~clk;

    ppage_validator u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
        .byte_data(byte_data), .param_valid(param_valid), .param_fail(param_fail),
        .accepted_copy(accepted_copy), .bytes_per_page(bytes_per_page),
        .spare_bytes_per_page(spare_bytes_per_page), .pages_per_block(pages_per_block),
        .blocks_per_lun(blocks_per_lun), .lun_count(lun_count),
        .col_addr_cycles(col_addr_cycles), .row_addr_cycles(row_addr_cycles)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Copy kinds: 0 clean, 1 two signature bytes wrong (still passes),
    // 2 three signature bytes wrong, 3 payload byte 60 changed after CRC,
    // 4 stored CRC high byte changed, 5 byte 253 changed after CRC,
    // 6 bytes 0,2,3 wrong (only one signature match).
    // Entry: {gap, kind2, kind1, kind0}
    localparam logic [9:0] SCN [8] = '{
        {1'b0, 3'd0, 3'd0, 3'd0},
        {1'b1, 3'd0, 3'd0, 3'd1},
        {1'b0, 3'd0, 3'd0, 3'd2},
        {1'b1, 3'd0, 3'd4, 3'd3},
        {1'b0, 3'd1, 3'd6, 3'd5},
        {1'b0, 3'd3, 3'd3, 3'd3},
        {1'b1, 3'd4, 3'd6, 3'd2},
        {1'b0, 3'd0, 3'd0, 3'd4}
    };

    logic [7:0] pg [256];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] e_bpp(input int s);  return 32'h0000_0800 + (32'(s) << 24) + 32'(s); endfunction
    function automatic logic [15:0] e_spare(input int s); return 16'h0040 + (16'(s) << 8); endfunction
    function automatic logic [31:0] e_ppb(input int s);  return 32'h0000_0040 + (32'(s) << 16); endfunction
    function automatic logic [31:0] e_bpl(input int s);  return 32'h0000_0400 + (32'(s) << 20) + 32'(s * 3); endfunction
    function automatic logic [7:0]  e_luns(input int s); return 8'(s + 1); endfunction
    function automatic logic [3:0]  e_col(input int s);  return 4'((s % 7) + 1); endfunction
    function automatic logic [3:0]  e_row(input int s);  return 4'((s % 5) + 2); endfunction

    function automatic logic [15:0] ref_crc();
        logic [15:0] c = 16'h4F4E;
        for (int j = 0; j < 254; j++) begin
            c ^= {pg[j], 8'h00};
            for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
        end
        return c;
    endfunction

    task automatic build(input int s, input int kind);
        logic [15:0] c;
        for (int i = 0; i < 256; i++) pg[i] = 8'(i * 13 + s * 5 + 1);
        pg[0] = "O"; pg[1] = "N"; pg[2] = "F"; pg[3] = "I";
        for (int k = 0; k < 4; k++) pg[80 + k] = e_bpp(s)[8*k +: 8];
        for (int k = 0; k < 2; k++) pg[84 + k] = e_spare(s)[8*k +: 8];
        for (int k = 0; k < 4; k++) pg[92 + k] = e_ppb(s)[8*k +: 8];
        for (int k = 0; k < 4; k++) pg[96 + k] = e_bpl(s)[8*k +: 8];
        pg[100] = e_luns(s);
        pg[101] = {e_col(s), e_row(s)};
        if (kind == 1) begin pg[1] ^= 8'h20; pg[3] ^= 8'h01; end
        if (kind == 2) begin pg[0] ^= 8'h01; pg[1] ^= 8'h02; pg[2] ^= 8'h04; end
        if (kind == 6) begin pg[0] ^= 8'h10; pg[2] ^= 8'h08; pg[3] ^= 8'h40; end
        c = ref_crc();
        pg[254] = c[7:0];
        pg[255] = c[15:8];
        if (kind == 3) pg[60]  ^= 8'h04;
        if (kind == 4) pg[255] ^= 8'h80;
        if (kind == 5) pg[253] ^= 8'h01;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Sends the first n bytes of pg; ends at the negedge after the last edge
    task automatic send_bytes(input bit gap, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gap && i % 4 == 0 && i != 0) begin
                byte_valid = 1'b0; byte_data = ~pg[i];
                @(negedge clk);
            end
            byte_valid = 1'b1; byte_data = pg[i];
        end
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic check_geom(input int s, input string req);
        chk(bytes_per_page == e_bpp(s), req, "bytes_per_page", bytes_per_page, e_bpp(s));
        chk(spare_bytes_per_page == e_spare(s), req, "spare_bytes", spare_bytes_per_page, e_spare(s));
        chk(pages_per_block == e_ppb(s), req, "pages_per_block", pages_per_block, e_ppb(s));
        chk(blocks_per_lun == e_bpl(s), req, "blocks_per_lun", blocks_per_lun, e_bpl(s));
        chk(lun_count == e_luns(s), req, "lun_count", lun_count, e_luns(s));
        chk(col_addr_cycles == e_col(s), "R7", "col_addr_cycles", col_addr_cycles, e_col(s));
        chk(row_addr_cycles == e_row(s), "R7", "row_addr_cycles", row_addr_cycles, e_row(s));
    endtask

    initial begin
        int last_seed;
        int last_copy;
        bit quiet;
        rst_n = 1'b0; start = 1'b0; byte_valid = 1'b0; byte_data = '0;
        last_seed = -1; last_copy = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(param_valid == 0 && param_fail == 0, "R1", "pulses in reset", {param_valid, param_fail}, 0);
        chk(bytes_per_page == 0 && lun_count == 0 && accepted_copy == 0 && row_addr_cycles == 0,
            "R1", "geometry in reset", bytes_per_page, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(blocks_per_lun == 0 && param_valid == 0, "R1", "after release", blocks_per_lun, 0);

        // Table walk: R2..R8, R10
        for (int s = 0; s < 8; s++) begin
            bit gap = SCN[s][9];
            bit done = 1'b0;
            pulse_start();
            for (int c = 0; c < 3 && !done; c++) begin
                int kind = int'(SCN[s][3*c +: 3]);
                int seed = s * 3 + c + 1;
                build(seed, kind);
                send_bytes(gap, 256);
                if (kind == 0 || kind == 1) begin
                    // R4 R10: accepted copy
                    chk(param_valid == 1 && param_fail == 0, "R4", $sformatf("accept scen %0d copy %0d", s, c),
                        {param_valid, param_fail}, 2'b10);
                    chk(accepted_copy == 2'(c), "R5", "accepted_copy", accepted_copy, c);
                    check_geom(seed, "R6");
                    @(negedge clk);
                    chk(param_valid == 0, "R8", "valid pulse width", param_valid, 0);
                    last_seed = seed; last_copy = c;
                    done = 1'b1;
                end else if (c < 2) begin
                    // R2 R3 R5: rejection moves on silently
                    chk(param_valid == 0 && param_fail == 0, (kind == 2 || kind == 6) ? "R3" : "R2",
                        $sformatf("reject scen %0d copy %0d kind %0d", s, c, kind),
                        {param_valid, param_fail}, 0);
                end else begin
                    chk(param_fail == 1 && param_valid == 0, "R5", $sformatf("fail scen %0d", s),
                        {param_valid, param_fail}, 2'b01);
                    // R8: rejected fields never shown
                    check_geom(last_seed, "R8");
                    chk(accepted_copy == 2'(last_copy), "R8", "accepted_copy held", accepted_copy, last_copy);
                    @(negedge clk);
                    chk(param_fail == 0, "R5", "fail pulse width", param_fail, 0);
                end
            end
        end

        // R9: restart partway through a copy
        pulse_start();
        build(40, 3);
        send_bytes(1'b0, 100);
        pulse_start();
        build(41, 0);
        send_bytes(1'b0, 256);
        chk(param_valid == 1 && accepted_copy == 0, "R9", "restart accept copy 0",
            {param_valid, accepted_copy}, 3'b100);
        check_geom(41, "R9");

        // R9: bytes while idle are ignored
        build(42, 0);
        quiet = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (param_valid || param_fail) quiet = 1'b0;
            byte_valid = 1'b1; byte_data = pg[i % 256];
        end
        @(negedge clk);
        byte_valid = 1'b0;
        if (param_valid || param_fail) quiet = 1'b0;
        @(negedge clk);
        if (param_valid || param_fail) quiet = 1'b0;
        chk(quiet, "R9", "no pulse while idle", !quiet, 0);
        check_geom(41, "R9");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule